// File: doc/BRIEF.md
# Scan Chain Test Controller

This block wraps a two-stage pipeline so that every register bit can be reached from one serial pin. The first stage is fed from the system input through a combinational function. A second combinational function sits between the first and second stages. In normal operation both stages load their parallel data on every clock. In test operation every register bit joins one serial shift path, from the scan input, through stage A, then through stage B, to the scan output.

A built-in sequencer runs a full test pattern after a single start request. It shifts a stimulus in over as many cycles as the chain has bits. It then lowers the test select for one functional capture clock. Finally it shifts the captured response out while the next stimulus comes in behind it. A one-cycle done flag marks the end of each pattern. If start is held during the final shift-out cycle, the sequencer goes straight to the next capture, so each further pattern costs the chain length plus one cycle.

Top module: `scan_test_ctrl`

## Requirements
- R1: While reset is asserted, and in the first idle cycle after it, both stages hold zero. The outputs test_mode_o, done_o, scan_out_o and sys_out_o are all zero.
- R2: Outside the shift phases, stage A loads fa(sys_in_i) on every clock and stage B loads fb(stage A). Here fa(x) = x XOR (x rotated left by one), and fb(y) = (y + (y rotated right by one)) mod 2^W. sys_out_o shows stage B, so an input appears at sys_out_o two clocks after it is applied.
- R3: Chain order. With chain vector C = {A, B} of L = 2W bits, each shift moves scan_in_i into C[L-1] and moves C[i+1] into C[i]. scan_out_o is C[0], which is bit 0 of stage B. After L shifts, the bit sent in the k-th shift cycle sits at C[k].
- R4: A start request sampled in idle raises test_mode_o on the next cycle. The shift-in phase then lasts exactly L cycles, with test_mode_o high in each of them.
- R5: After shift-in, test_mode_o is low for exactly one capture cycle. In that cycle both stages load their functional values from sys_in_i and from the shifted-in stage A contents.
- R6: Shift-out lasts L cycles with test_mode_o high. In shift-out cycle k, scan_out_o shows response bit k, where response = {fa(sys_in at capture), fb(stimulus upper half)}. scan_in_i is shifted in during the same cycles.
- R7: done_o is high for exactly one cycle, the cycle right after the final shift-out clock. With no chaining, the block is back in idle on the cycle after that.
- R8: If start_i is high in the final shift-out cycle, the next cycle is a capture cycle. The bits shifted in during shift-out are used as the next stimulus, so each chained pattern takes L+1 cycles.
- R9: start_i has no effect during shift-in, during capture, or during any shift-out cycle except the final one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Test pattern request |
| scan_in_i | input | 1 | Serial chain input |
| sys_in_i | input | W | Parallel system data into logic A |
| sys_out_o | output | W | Stage B contents |
| scan_out_o | output | 1 | Serial chain output (stage B bit 0) |
| test_mode_o | output | 1 | Test select driven to all scan cells |
| done_o | output | 1 | One-cycle end-of-pattern pulse |

## Verification
The bench checks the capture slot cycle by cycle. A sequencer that shifts one cycle too many or too few, or that holds capture for two cycles, moves the response by a bit and every compared response goes wrong. It also sends patterns where the next stimulus enters during shift-out. A design that clears the chain before the chained capture, or that adds an idle cycle, would return a response computed from the wrong stimulus. Start pulses placed in the middle of shift-in and shift-out catch a sequencer that restarts, and inputs applied in idle catch a swapped chain order or a wrong stage function.

// File: rtl/scan_pkg.sv
`timescale 1ns/1ps
package scan_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT_IN,
        ST_CAPTURE,
        ST_SHIFT_OUT,
        ST_DONE
    } seq_state_e;
endpackage

// File: rtl/stage_logic_a.sv
`timescale 1ns/1ps
module stage_logic_a #(
    parameter int W = 8
) (
    input  logic [W-1:0] x_i,
    output logic [W-1:0] y_o
);
    always_comb begin
        y_o = x_i ^ {x_i[W-2:0], x_i[W-1]};
    end
endmodule

// File: rtl/stage_logic_b.sv
`timescale 1ns/1ps
module stage_logic_b #(
    parameter int W = 8
) (
    input  logic [W-1:0] x_i,
    output logic [W-1:0] y_o
);
    always_comb begin
        y_o = x_i + {x_i[0], x_i[W-1:1]};
    end
endmodule

// File: rtl/scan_stage.sv
`timescale 1ns/1ps
module scan_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         test_mode_i,
    input  logic [W-1:0] d_i,
    input  logic         scan_in_i,
    output logic [W-1:0] q_o,
    output logic         scan_out_o
);
    logic [W-1:0] q_q;
    logic [W-1:0] q_d;
    logic [W-1:0] ser_in;

    // Each cell: 2:1 mux in front of a flop; serial path runs high bit to low bit
    for (genvar i = 0; i < W; i++) begin : g_cell
        if (i == W-1) begin : g_head
            assign ser_in[i] = scan_in_i;
        end else begin : g_link
            assign ser_in[i] = q_q[i+1];
        end

        always_comb begin
            q_d[i] = test_mode_i ? ser_in[i] : d_i[i];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_q[i] <= 1'b0;
            else        q_q[i] <= q_d[i];
        end
    end

    assign q_o        = q_q;
    assign scan_out_o = q_q[0];
endmodule

// File: rtl/scan_seq.sv
`timescale 1ns/1ps
module scan_seq
    import scan_pkg::*;
#(
    parameter int CHAIN_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic test_mode_o,
    output logic done_o
);
    localparam int CNT_W = (CHAIN_LEN > 2) ? $clog2(CHAIN_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CHAIN_LEN - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } seq_regs_t;

    seq_regs_t r_q, r_d;
    logic      last;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        last     = (r_q.cnt == CNT_LAST);
        case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state = ST_SHIFT_IN;
                    r_d.cnt   = '0;
                end
            end
            ST_SHIFT_IN: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (last) begin
                    r_d.cnt   = '0;
                    r_d.state = ST_CAPTURE;
                end
            end
            ST_CAPTURE: begin
                r_d.state = ST_SHIFT_OUT;
                r_d.cnt   = '0;
            end
            ST_SHIFT_OUT: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (last) begin
                    r_d.cnt   = '0;
                    r_d.done  = 1'b1;
                    r_d.state = start_i ? ST_CAPTURE : ST_DONE;
                end
            end
            ST_DONE: begin
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
                r_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.cnt   <= '0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign test_mode_o = (r_q.state == ST_SHIFT_IN) || (r_q.state == ST_SHIFT_OUT);
    assign done_o      = r_q.done;

    assert_start_enters_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && start_i) |=> test_mode_o);

    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= CNT_LAST);

    assert_capture_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_CAPTURE) |=> test_mode_o);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SHIFT_IN && r_q.cnt != CNT_LAST) |=> (r_q.state == ST_SHIFT_IN));
endmodule

// File: rtl/scan_test_ctrl.sv
`timescale 1ns/1ps
module scan_test_ctrl #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         scan_in_i,
    input  logic [W-1:0] sys_in_i,
    output logic [W-1:0] sys_out_o,
    output logic         scan_out_o,
    output logic         test_mode_o,
    output logic         done_o
);
    localparam int CHAIN_LEN = 2 * W;

    logic [W-1:0] logic_a_out;
    logic [W-1:0] logic_b_out;
    logic [W-1:0] stage_a_q;
    logic         link_ab;

    stage_logic_a #(.W(W)) u_logic_a (.x_i(sys_in_i), .y_o(logic_a_out));

    scan_stage #(.W(W)) u_stage_a (
        .clk        (clk),
        .rst_n      (rst_n),
        .test_mode_i(test_mode_o),
        .d_i        (logic_a_out),
        .scan_in_i  (scan_in_i),
        .q_o        (stage_a_q),
        .scan_out_o (link_ab)
    );

    stage_logic_b #(.W(W)) u_logic_b (.x_i(stage_a_q), .y_o(logic_b_out));

    scan_stage #(.W(W)) u_stage_b (
        .clk        (clk),
        .rst_n      (rst_n),
        .test_mode_i(test_mode_o),
        .d_i        (logic_b_out),
        .scan_in_i  (link_ab),
        .q_o        (sys_out_o),
        .scan_out_o (scan_out_o)
    );

    scan_seq #(.CHAIN_LEN(CHAIN_LEN)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .test_mode_o(test_mode_o),
        .done_o     (done_o)
    );

    assert_normal_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode_o |=> (sys_out_o == $past(logic_b_out)));

    assert_scan_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode_o |=> (scan_out_o == $past(sys_out_o[1])));

    assert_done_after_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(test_mode_o));
endmodule

// File: tb/scan_test_ctrl_bench.sv
`timescale 1ns/1ps
module scan_test_ctrl_bench;
    localparam int W = 8;
    localparam int L = 2 * W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         scan_in_i = 1'b0;
    logic [W-1:0] sys_in_i = '0;
    logic [W-1:0] sys_out_o;
    logic         scan_out_o;
    logic         test_mode_o;
    logic         done_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    scan_test_ctrl #(.W(W)) u_scan_test_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .scan_in_i(scan_in_i),
        .sys_in_i(sys_in_i), .sys_out_o(sys_out_o), .scan_out_o(scan_out_o),
        .test_mode_o(test_mode_o), .done_o(done_o)
    );

    function automatic logic [W-1:0] f_a(input logic [W-1:0] x);
        return x ^ {x[W-2:0], x[W-1]};
    endfunction

    function automatic logic [W-1:0] f_b(input logic [W-1:0] y);
        return y + {y[0], y[W-1:1]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // From idle: request, then drive the stimulus bit by bit; returns at the capture-cycle negedge
    task automatic shift_in(input logic [L-1:0] stim, input bit poke);
        @(negedge clk);
        start_i = 1'b1;
        for (int k = 0; k < L; k++) begin
            @(negedge clk);
            start_i = poke && (k == 3);
            check(test_mode_o == 1'b1, "R4 shift-in test_mode", test_mode_o, 1);
            scan_in_i = stim[k];
        end
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Entered at the capture-cycle negedge
    task automatic capture_out(input logic [W-1:0] din, input logic [L-1:0] cur,
                               input logic [L-1:0] nxt, input bit chain, input bit poke);
        logic [L-1:0] resp;
        logic [L-1:0] expv;
        check(test_mode_o == 1'b0, "R5 capture test_mode low", test_mode_o, 0);
        sys_in_i = din;
        for (int k = 0; k < L; k++) begin
            @(negedge clk);
            check(test_mode_o == 1'b1, "R6 shift-out test_mode", test_mode_o, 1);
            resp[k]   = scan_out_o;
            scan_in_i = nxt[k];
            start_i   = (k == L-1) ? chain : (poke && k == 2);
        end
        @(negedge clk);
        start_i = 1'b0;
        check(done_o == 1'b1, "R7 done pulse", done_o, 1);
        expv = {f_a(din), f_b(cur[L-1:W])};
        check(resp == expv, chain ? "R8 R6 chained response" : "R6 R5 response", resp, expv);
        if (chain) begin
            check(test_mode_o == 1'b0, "R8 direct capture", test_mode_o, 0);
        end else begin
            @(negedge clk);
            check(done_o == 1'b0, "R7 done one cycle", done_o, 0);
            check(test_mode_o == 1'b0, "R7 back to idle", test_mode_o, 0);
        end
    endtask

    task automatic normal_run(input int n);
        logic [W-1:0] hist[$];
        for (int i = 0; i < n; i++) begin
            logic [W-1:0] x;
            @(negedge clk);
            if (i >= 2)
                check(sys_out_o == f_b(f_a(hist[i-2])), "R2 normal pipeline", sys_out_o, f_b(f_a(hist[i-2])));
            x = (i == 0) ? '1 : W'($urandom);
            hist.push_back(x);
            sys_in_i = x;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [L-1:0] s0, s1, s2;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(sys_out_o == '0 && scan_out_o == 1'b0, "R1 reset regs", {sys_out_o, scan_out_o}, 0);
        check(test_mode_o == 1'b0 && done_o == 1'b0, "R1 reset flags", {test_mode_o, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sys_out_o == '0 && test_mode_o == 1'b0, "R1 idle after reset", sys_out_o, 0);

        normal_run(20);

        // R3 directed: single one placed at chain position 0 and at the top of stage A
        s0 = L'(1);
        shift_in(s0, 1'b0);
        capture_out('0, s0, '0, 1'b0, 1'b0);
        s0 = {1'b1, {(L-1){1'b0}}};
        shift_in(s0, 1'b0);
        capture_out(8'h81, s0, '0, 1'b0, 1'b0);
        s0 = '1;
        shift_in(s0, 1'b0);
        capture_out('1, s0, '0, 1'b0, 1'b0);

        // Random single patterns, some with stray start pulses (R9)
        for (int p = 0; p < 8; p++) begin
            s0 = L'($urandom);
            shift_in(s0, p[0]);
            capture_out(W'($urandom), s0, '0, 1'b0, p[1]);
        end

        // Chained back-to-back patterns (R8)
        s0 = L'($urandom);
        s1 = L'($urandom);
        s2 = L'($urandom);
        shift_in(s0, 1'b0);
        capture_out(W'($urandom), s0, s1, 1'b1, 1'b0);
        capture_out(W'($urandom), s1, s2, 1'b1, 1'b1);
        capture_out(W'($urandom), s2, '0, 1'b0, 1'b0);

        normal_run(10);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule